// File: doc/BRIEF.md
# Chroma Row-Averaging Downsampler

This block takes a 4:2:2 picture arriving one pixel per beat, in raster order, and turns it into a planar 4:2:0 picture held in an external synchronous SRAM. Each beat carries one luma sample and one chroma sample. The chroma sample alternates by column: even columns carry Cb and odd columns carry Cr. Luma is written straight through. On every even line the chroma samples are kept in a one-line store. On the odd line that follows, each incoming chroma sample is averaged with the stored sample from the same column, and the result is written out. This yields one chroma line per line pair, at half the horizontal and half the vertical resolution.

The three components go to three planes laid out back to back: luma first, then Cb, then Cr, each in raster order. The SRAM accepts at most one write per cycle. An odd line produces two writes per beat, so writes pass through a small queue and the input is held off when the queue has no room for two more entries. A one-cycle frame-done pulse marks the write that closes the frame.

The controller has three states. ST_IDLE waits for a start-of-frame beat. ST_EVEN is an even line that fills the line store. ST_ODD is an odd line that averages and writes chroma. Its transitions are:
- start (ST_IDLE to ST_EVEN) on a start-of-frame beat;
- line-end (ST_EVEN to ST_ODD) after the last column of an even line;
- pair-end (ST_ODD to ST_EVEN) after the last column of an odd line that is not the last line;
- frame-end (ST_ODD to ST_IDLE) after the last column of the last line;
- restart (any state to ST_EVEN) on a start-of-frame beat.

Top module: `chroma_vdown_top`

## Requirements
- R1: While reset is applied and in the first cycle after it, `wr_en` and `frame_done` are 0 and `in_ready` is 1.
- R2: Every accepted frame pixel at row r, column c produces a luma write of `in_y` unchanged to address r*WIDTH+c. This write is issued before any chroma write caused by the same beat.
- R3: A pixel on an even row (row 0, 2, …) produces no chroma write. A full even line therefore yields exactly WIDTH writes.
- R4: A pixel on an odd row r produces one chroma write after its luma write. The data is (a+b+1)>>1, where a is the chroma at the same column of row r-1 and b is `in_c`. The sum is computed without wrap, so 255 and 255 give 255.
- R5: In that chroma write, even columns are Cb, written to WIDTH*HEIGHT + (r>>1)*(WIDTH/2) + (c>>1). Odd columns are Cr, written to WIDTH*HEIGHT + WIDTH*HEIGHT/4 + (r>>1)*(WIDTH/2) + (c>>1).
- R6: At most one write is issued per cycle. Writes leave in the order they were generated, and none is lost or duplicated. `in_ready` goes low while the write queue cannot take two entries, which happens during back-to-back odd-line input.
- R7: `frame_done` is a one-cycle pulse. It is raised together with the Cr write of pixel (HEIGHT-1, WIDTH-1), and at no other time.
- R8: A beat with `in_sof`=1 is taken as pixel (0,0) and resets all row, column and address counters. This holds in any state, including partway through a frame.
- R9: In ST_IDLE (before the first start-of-frame, or after the last pixel of a frame), beats with `in_sof`=0 are accepted and discarded. They cause no writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Beat accepted on this edge when high together with in_valid |
| in_sof | input | 1 | Beat is pixel (0,0) of a new frame |
| in_y | input | DW | Luma sample |
| in_c | input | DW | Chroma sample: Cb on even columns, Cr on odd columns |
| wr_en | output | 1 | SRAM write strobe |
| wr_addr | output | AW | SRAM word address (AW = clog2 of 1.5*WIDTH*HEIGHT) |
| wr_data | output | DW | SRAM write data |
| frame_done | output | 1 | Pulse with the final Cr write of a frame |

## Verification
The averaging path is driven with four chroma patterns, each telling apart a different kind of error:
- A diagonal ramp exposes column or line-store index errors.
- An all-255 frame exposes a sum that wraps.
- Odd pairs whose exact mean ends in one half expose truncation where rounding is required.
- A scrambled pattern exposes Cb/Cr swaps and plane mix-ups.

One ramp frame has bubbles in its input, to show that gaps in `in_valid` shift nothing. A partial single line checks that even lines write no chroma. A start-of-frame beat partway through an odd line proves the restart. Stray beats before and after a frame prove that idle input is discarded.

// File: rtl/cvd_pkg.sv
`timescale 1ns/1ps
package cvd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_EVEN = 2'd1,
        ST_ODD  = 2'd2
    } cvd_state_t;
endpackage

// File: rtl/cvd_linebuf.sv
`timescale 1ns/1ps
// One-line chroma store: one bank for Cb and one for Cr, each HALF_W deep.
module cvd_linebuf #(
    parameter int HALF_W = 160,
    parameter int DW     = 8,
    parameter int IW     = 8
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic          sel,
    input  logic [IW-1:0] idx,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] rd_data
);
    logic [DW-1:0] rd_bank [2];

    for (genvar b = 0; b < 2; b++) begin : g_bank
        logic [DW-1:0] mem [HALF_W];
        always_ff @(posedge clk) begin
            if (wr_en && (sel == 1'(b)))
                mem[idx] <= wr_data;
        end
        assign rd_bank[b] = mem[idx];
    end

    assign rd_data = rd_bank[sel];
endmodule

// File: rtl/cvd_wrfifo.sv
`timescale 1ns/1ps
// Write queue: up to two pushes and one pop per cycle. DEPTH must be a power of two.
module cvd_wrfifo #(
    parameter int EW    = 26,
    parameter int DEPTH = 4,
    parameter int PW    = 2,
    parameter int CW    = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push0,
    input  logic [EW-1:0] d0,
    input  logic          push1,
    input  logic [EW-1:0] d1,
    input  logic          pop,
    output logic [EW-1:0] head,
    output logic [CW-1:0] cnt
);
    logic [EW-1:0] mem [DEPTH];
    logic [PW-1:0] wptr, rptr;

    always_ff @(posedge clk) begin
        if (push0) mem[wptr] <= d0;
        if (push1) mem[wptr + PW'(1)] <= d1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr <= '0;
            rptr <= '0;
            cnt  <= '0;
        end else begin
            wptr <= wptr + PW'(push0) + PW'(push1);
            rptr <= rptr + PW'(pop);
            cnt  <= cnt + CW'(push0) + CW'(push1) - CW'(pop);
        end
    end

    assign head = mem[rptr];
endmodule

// File: rtl/cvd_ctrl.sv
`timescale 1ns/1ps
// Frame walker: tracks row, column and plane addresses, and builds the write entries.
module cvd_ctrl
    import cvd_pkg::*;
#(
    parameter int W  = 320,
    parameter int H  = 240,
    parameter int DW = 8,
    parameter int AW = 17,
    parameter int IW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_ready,
    input  logic              in_sof,
    input  logic [DW-1:0]     in_y,
    input  logic [DW-1:0]     in_c,
    input  logic [DW-1:0]     lb_rd,
    output logic              lb_we,
    output logic              lb_sel,
    output logic [IW-1:0]     lb_idx,
    output logic              push0,
    output logic [AW+DW:0]    e0,
    output logic              push1,
    output logic [AW+DW:0]    e1,
    output cvd_state_t        state
);
    localparam int YSZ = W * H;
    localparam int CSZ = YSZ / 4;
    localparam int RW  = $clog2(H);
    localparam int CLW = $clog2(W);
    localparam int CIW = $clog2(CSZ + 1);
    localparam logic [AW-1:0] CB_BASE = AW'(YSZ);
    localparam logic [AW-1:0] CR_BASE = AW'(YSZ + CSZ);

    cvd_state_t     state_n;
    logic [RW-1:0]  row, row_n, cur_row;
    logic [CLW-1:0] col, col_n, cur_col;
    logic [AW-1:0]  y_addr, y_addr_n, cur_yaddr, caddr;
    logic [CIW-1:0] c_idx, c_idx_n, cur_cidx;
    logic           take, odd, is_cr, row_end, frame_end;
    logic [DW-1:0]  avg;

    // State register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            row    <= '0;
            col    <= '0;
            y_addr <= '0;
            c_idx  <= '0;
        end else begin
            state  <= state_n;
            row    <= row_n;
            col    <= col_n;
            y_addr <= y_addr_n;
            c_idx  <= c_idx_n;
        end
    end

    // Next-state and output process
    always_comb begin
        cur_row   = in_sof ? '0 : row;
        cur_col   = in_sof ? '0 : col;
        cur_yaddr = in_sof ? '0 : y_addr;
        cur_cidx  = in_sof ? '0 : c_idx;
        take      = in_valid && in_ready && (in_sof || (state != ST_IDLE));
        odd       = cur_row[0];
        is_cr     = cur_col[0];
        row_end   = (cur_col == CLW'(W - 1));
        frame_end = row_end && (cur_row == RW'(H - 1));
        avg       = DW'(({1'b0, lb_rd} + {1'b0, in_c} + (DW + 1)'(1)) >> 1);
        caddr     = (is_cr ? CR_BASE : CB_BASE) + AW'(cur_cidx);

        lb_we  = take && !odd;
        lb_sel = is_cr;
        lb_idx = IW'(cur_col >> 1);
        push0  = take;
        e0     = {1'b0, cur_yaddr, in_y};
        push1  = take && odd;
        e1     = {frame_end, caddr, avg};

        state_n  = state;
        row_n    = row;
        col_n    = col;
        y_addr_n = y_addr;
        c_idx_n  = c_idx;
        if (take) begin
            y_addr_n = cur_yaddr + AW'(1);
            c_idx_n  = cur_cidx + CIW'(odd && is_cr);
            if (row_end) begin
                col_n = '0;
                row_n = cur_row + RW'(1);
            end else begin
                col_n = cur_col + CLW'(1);
                row_n = cur_row;
            end
        end

        unique case (state)
            ST_IDLE: if (take) state_n = ST_EVEN;               // start
            ST_EVEN: if (take) begin
                if (in_sof)       state_n = ST_EVEN;            // restart
                else if (row_end) state_n = ST_ODD;             // line-end
            end
            ST_ODD: if (take) begin
                if (in_sof)         state_n = ST_EVEN;          // restart
                else if (frame_end) state_n = ST_IDLE;          // frame-end
                else if (row_end)   state_n = ST_EVEN;          // pair-end
            end
            default: state_n = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/chroma_vdown_top.sv
`timescale 1ns/1ps
module chroma_vdown_top
    import cvd_pkg::*;
#(
    parameter int WIDTH  = 320,
    parameter int HEIGHT = 240,
    parameter int DW     = 8,
    parameter int DEPTH  = 4,
    localparam int TOTAL = WIDTH * HEIGHT + (WIDTH * HEIGHT) / 2,
    localparam int AW    = $clog2(TOTAL)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic          in_sof,
    input  logic [DW-1:0] in_y,
    input  logic [DW-1:0] in_c,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output logic          frame_done
);
    localparam int HALF_W = WIDTH / 2;
    localparam int IW     = $clog2(HALF_W);
    localparam int EW     = 1 + AW + DW;
    localparam int PW     = $clog2(DEPTH);
    localparam int CW     = $clog2(DEPTH + 1);

    logic          lb_we, lb_sel, push0, push1, pop;
    logic [IW-1:0] lb_idx;
    logic [DW-1:0] lb_rd, h_data;
    logic [EW-1:0] e0, e1, head;
    logic [CW-1:0] fifo_cnt;
    logic [AW-1:0] h_addr;
    logic          h_last;
    cvd_state_t    ctrl_state;

    assign in_ready = (fifo_cnt <= CW'(DEPTH - 2));
    assign pop      = (fifo_cnt != '0);
    assign {h_last, h_addr, h_data} = head;

    cvd_ctrl #(.W(WIDTH), .H(HEIGHT), .DW(DW), .AW(AW), .IW(IW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_sof(in_sof), .in_y(in_y), .in_c(in_c), .lb_rd(lb_rd),
        .lb_we(lb_we), .lb_sel(lb_sel), .lb_idx(lb_idx),
        .push0(push0), .e0(e0), .push1(push1), .e1(e1), .state(ctrl_state)
    );

    cvd_linebuf #(.HALF_W(HALF_W), .DW(DW), .IW(IW)) u_lb (
        .clk(clk), .wr_en(lb_we), .sel(lb_sel), .idx(lb_idx),
        .wr_data(in_c), .rd_data(lb_rd)
    );

    cvd_wrfifo #(.EW(EW), .DEPTH(DEPTH), .PW(PW), .CW(CW)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push0(push0), .d0(e0), .push1(push1),
        .d1(e1), .pop(pop), .head(head), .cnt(fifo_cnt)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_en      <= 1'b0;
            wr_addr    <= '0;
            wr_data    <= '0;
            frame_done <= 1'b0;
        end else begin
            wr_en      <= pop;
            frame_done <= pop && h_last;
            if (pop) begin
                wr_addr <= h_addr;
                wr_data <= h_data;
            end
        end
    end
endmodule

// File: rtl/cvd_checker.sv
`timescale 1ns/1ps
module cvd_checker
    import cvd_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int TOTAL = 115200,
    parameter int AW    = 17,
    parameter int CW    = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          in_sof,
    input logic          in_ready,
    input logic          wr_en,
    input logic [AW-1:0] wr_addr,
    input logic          frame_done,
    input logic [CW-1:0] fifo_cnt,
    input cvd_state_t    state
);
    assert_done_with_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> wr_en);

    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);

    assert_addr_in_map_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (int'(wr_addr) < TOTAL));

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        int'(fifo_cnt) <= DEPTH);

    assert_no_write_when_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_cnt == '0) |=> !wr_en);

    assert_idle_discard_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && in_valid && in_ready && !in_sof) |=> (fifo_cnt <= $past(fifo_cnt)));
endmodule

bind chroma_vdown_top cvd_checker #(.DEPTH(DEPTH), .TOTAL(TOTAL), .AW(AW), .CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
    .in_ready(in_ready), .wr_en(wr_en), .wr_addr(wr_addr),
    .frame_done(frame_done), .fifo_cnt(fifo_cnt), .state(ctrl_state)
);

// File: tb/sim_chroma_vdown_top.sv
`timescale 1ns/1ps
module sim_chroma_vdown_top;
    localparam int W = 8, H = 4, DW = 8, DEPTH = 4;
    localparam int YSZ = W * H, CSZ = YSZ / 4;
    localparam int AW = $clog2(YSZ + 2 * CSZ);

    logic clk = 1'b0, rst_n = 1'b0;
    logic in_valid = 1'b0, in_sof = 1'b0;
    logic [DW-1:0] in_y = '0, in_c = '0;
    logic in_ready, wr_en, frame_done;
    logic [AW-1:0] wr_addr;
    logic [DW-1:0] wr_data;

    always #2.5 clk = ~clk;

    chroma_vdown_top #(.WIDTH(W), .HEIGHT(H), .DW(DW), .DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_sof(in_sof), .in_y(in_y), .in_c(in_c), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .frame_done(frame_done)
    );

    int ex_addr [1024];
    int ex_data [1024];
    bit ex_done [1024];
    string ex_tag [1024];
    int ex_n = 0, mon_i = 0, n_wr = 0, n_done = 0;
    int mon_checks = 0, mon_fails = 0, checks = 0, fails = 0, stalls = 0;
    bit finished = 0;

    function automatic int y_of(int p, int r, int c);
        return (p * 37 + r * 8 + c * 3) & 255;
    endfunction

    function automatic int c_of(int p, int r, int c);
        case (p)
            0: return (r * 20 + c * 7) & 255;          // ramp
            1: return 255;                             // saturation
            2: return (r % 2 == 1) ? c * 30 + 1 : c * 30; // half-way rounding
            default: return ((r * 73 + c * 151 + 29) ^ (c << 4)) & 255;
        endcase
    endfunction

    task automatic push_exp(int a, int d, bit dn, string t);
        ex_addr[ex_n] = a; ex_data[ex_n] = d; ex_done[ex_n] = dn; ex_tag[ex_n] = t;
        ex_n++;
    endtask

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Write monitor: every SRAM write is compared with the next expected entry
    always @(negedge clk) begin
        if (rst_n && wr_en) begin
            mon_checks++;
            n_wr++;
            if (frame_done) n_done++;
            if (mon_i >= ex_n) begin
                mon_fails++;
                $display("FAIL R6 extra write actual addr=%0d data=%0d expected none", wr_addr, wr_data);
            end else begin
                if (int'(wr_addr) != ex_addr[mon_i] || int'(wr_data) != ex_data[mon_i]
                    || frame_done != ex_done[mon_i]) begin
                    mon_fails++;
                    $display("FAIL %s write %0d actual addr=%0d data=%0d done=%0d expected addr=%0d data=%0d done=%0d",
                             ex_tag[mon_i], mon_i, wr_addr, wr_data, frame_done,
                             ex_addr[mon_i], ex_data[mon_i], ex_done[mon_i]);
                end
                mon_i++;
            end
        end
    end

    task automatic send_beat(bit sof, int y, int c);
        @(negedge clk);
        in_valid = 1'b1; in_sof = sof; in_y = DW'(y); in_c = DW'(c);
        while (!in_ready) begin
            stalls++;
            @(negedge clk);
        end
        @(posedge clk);
    endtask

    task automatic go_idle();
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0;
    endtask

    task automatic drain();
        go_idle();
        repeat (24) @(negedge clk);
    endtask

    task automatic run_frame(int p, int npix, bit gaps);
        for (int k = 0; k < npix; k++) begin
            int r = k / W;
            int c = k % W;
            push_exp(r * W + c, y_of(p, r, c), 1'b0, "R2 luma");
            if (r % 2 == 1) begin
                int a = (r / 2) * (W / 2) + c / 2;
                int v = (c_of(p, r - 1, c) + c_of(p, r, c) + 1) / 2;
                bit last = (r == H - 1) && (c == W - 1);
                if (c % 2 == 1) push_exp(YSZ + CSZ + a, v, last, last ? "R7 R4 R5 Cr" : "R4 R5 Cr");
                else            push_exp(YSZ + a, v, 1'b0, "R4 R5 Cb");
            end
            send_beat(k == 0, y_of(p, r, c), c_of(p, r, c));
            if (gaps && (c % 3 == 1)) begin
                @(negedge clk);
                in_valid = 1'b0;
                @(posedge clk);
            end
        end
        go_idle();
    endtask

    task automatic finish_sim();
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", checks + mon_checks, fails + mon_fails);
        $finish;
    endtask

    initial begin
        int base;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(wr_en == 1'b0, "R1 wr_en in reset", int'(wr_en), 0);
        chk(frame_done == 1'b0, "R1 frame_done in reset", int'(frame_done), 0);
        chk(in_ready == 1'b1, "R1 in_ready in reset", int'(in_ready), 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(wr_en == 1'b0 && in_ready == 1'b1, "R1 after release", int'(wr_en), 0);

        // R9: stray beats before any start-of-frame
        for (int i = 0; i < 5; i++) send_beat(1'b0, 17 + i, 99);
        drain();
        chk(n_wr == 0, "R9 idle beats before frame", n_wr, 0);

        // Full frames: ramp with input bubbles, saturation, rounding, scrambled
        run_frame(0, W * H, 1'b1);
        drain();
        chk(mon_i == ex_n, "R6 ramp frame all writes issued", mon_i, ex_n);
        chk(n_done == 1, "R7 one done pulse per frame", n_done, 1);
        run_frame(1, W * H, 1'b0);
        run_frame(2, W * H, 1'b0);
        run_frame(3, W * H, 1'b0);
        drain();
        chk(n_done == 4, "R7 done pulses after four frames", n_done, 4);
        chk(stalls > 0, "R6 input held off on odd lines", stalls, 1);

        // R9: stray beats after a completed frame
        base = n_wr;
        for (int i = 0; i < 4; i++) send_beat(1'b0, 3, 200);
        drain();
        chk(n_wr == base, "R9 idle beats after frame", n_wr, base);

        // R3: a lone even line writes luma only
        base = n_wr;
        run_frame(0, W, 1'b0);
        drain();
        chk(n_wr - base == W, "R3 even line write count", n_wr - base, W);

        // R8: restart partway through an odd line, then a full frame
        run_frame(3, W + W / 2, 1'b0);
        run_frame(2, W * H, 1'b0);
        drain();
        chk(n_done == 5, "R8 restart frame completes", n_done, 5);
        chk(mon_i == ex_n, "R8 R6 all expected writes seen", mon_i, ex_n);
        chk(n_wr == ex_n, "R6 total write count", n_wr, ex_n);
        finish_sim();
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL R6 watchdog actual=hung expected=finished");
            finish_sim();
        end
    end
endmodule